// File: doc/BRIEF.md
# Two-Way Set-Associative Byte Load Cache

This block sits between a processor load port and a byte-wide backing memory. The processor presents a byte address with a load strobe. The cache answers with the addressed byte, and a flag tells whether the byte was already resident. The cache holds two sets of two ways. Each line covers an aligned two-byte block. A lookup compares the address tag against both ways of the selected set in the same cycle.

On a miss the load port reports busy while the cache reads the whole block from memory, one byte per request/ready handshake. The block is placed in a way chosen per set. The load then completes and is recorded as a miss. Two free-running counters record hits and misses so that the cache behaviour can be observed. Loads only: the cache takes no stores and keeps no dirty state.

Top module: `sa2c_load_cache`

## Requirements
- R1: The 5-bit byte address is read as tag = bits [4:2], set index = bit [1] and block offset = bit [0]. Two addresses that differ only in bit 0 share one line.
- R2: After reset, no line is valid, both counters are zero, and ld_busy, rsp_valid and mem_req are low. A block loaded before a reset misses again after it.
- R3: A load accepted while ld_busy is low and whose tag matches a valid way of its set returns the byte on rsp_data one cycle later, with rsp_valid=1 and rsp_hit=1. It issues no memory request, and hit_count rises by one in the response cycle.
- R4: A load that misses raises ld_busy from the cycle after acceptance until the response. mem_req reads the block bytes in ascending offset order, starting at the block-aligned address. mem_addr is held stable until mem_ready.
- R5: When a block fill completes, the requested byte is returned with rsp_valid=1 and rsp_hit=0. miss_count rises by one and hit_count is unchanged. The response follows the last mem_ready by two cycles.
- R6: A block may occupy either way of its set, so two blocks whose addresses share bit [1] can be resident together.
- R7: On a miss, an invalid way of the set is filled first, way 0 before way 1. When both ways are valid, the way least recently used is replaced.
- R8: Each set's recency state is updated on every hit and on every fill. After either event, the other way of that set is the next one to be replaced.
- R9: A strobe raised while ld_busy is high is ignored. It produces no response, no counter change and no fill of its block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load strobe |
| ld_addr | input | 5 | Byte address of the load |
| ld_busy | output | 1 | High while a miss is being serviced |
| rsp_valid | output | 1 | One-cycle pulse with the load result |
| rsp_data | output | 8 | Loaded byte |
| rsp_hit | output | 1 | 1 when the load hit, 0 when it missed |
| hit_count | output | 16 | Number of hits since reset |
| miss_count | output | 16 | Number of misses since reset |
| mem_req | output | 1 | Memory byte read request |
| mem_addr | output | 5 | Memory byte address |
| mem_ready | input | 1 | Memory returns mem_data this cycle |
| mem_data | input | 8 | Byte from memory |

## Verification
The hardest case to reach is a replacement decision that depends on recency history. The way evicted is visible only through which later load misses. A specific interleaving is needed to expose it: two fills, then hits that reverse recency, then a third tag in the same set. The stimulus replays such address sequences in both sets and checks the hit flag of every load. If recency were not refreshed on hits, a different block would be evicted and a later load would flip between hit and miss. Ignored strobes are driven during a fill, then followed by a load of the ignored address, which must miss.

// File: rtl/sa2c_pkg.sv
package sa2c_pkg;
   typedef enum logic [1:0] {
      FILL_IDLE = 2'd0,
      FILL_BEAT = 2'd1,
      FILL_DONE = 2'd2
   } fill_state_e;
endpackage

// File: rtl/sa2c_way.sv
// One way of the cache: valid bit, tag and line data for every set.
module sa2c_way #(
   parameter int TAG_W     = 3,
   parameter int IDX_W     = 1,
   parameter int LINE_BITS = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [IDX_W-1:0]     rd_idx_i,
   output logic                 rd_valid_o,
   output logic [TAG_W-1:0]     rd_tag_o,
   output logic [LINE_BITS-1:0] rd_line_o,
   input  logic                 wr_en_i,
   input  logic [IDX_W-1:0]     wr_idx_i,
   input  logic [TAG_W-1:0]     wr_tag_i,
   input  logic [LINE_BITS-1:0] wr_line_i
);
   localparam int SETS = 1 << IDX_W;

   logic [SETS-1:0]      valid_q;
   logic [TAG_W-1:0]     tag_q  [SETS];
   logic [LINE_BITS-1:0] line_q [SETS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         for (int s = 0; s < SETS; s++) begin
            tag_q[s]  <= '0;
            line_q[s] <= '0;
         end
      end else if (wr_en_i) begin
         valid_q[wr_idx_i] <= 1'b1;
         tag_q[wr_idx_i]   <= wr_tag_i;
         line_q[wr_idx_i]  <= wr_line_i;
      end
   end

   assign rd_valid_o = valid_q[rd_idx_i];
   assign rd_tag_o   = tag_q[rd_idx_i];
   assign rd_line_o  = line_q[rd_idx_i];
endmodule

// File: rtl/sa2c_repl.sv
// Per-set recency bit for a two-way cache; the bit names the way to evict next.
module sa2c_repl #(
   parameter int IDX_W = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx_i,
   input  logic [1:0]       way_valid_i,
   output logic             victim_o,
   input  logic             touch_en_i,
   input  logic [IDX_W-1:0] touch_idx_i,
   input  logic             touch_way_i
);
   localparam int SETS = 1 << IDX_W;

   logic [SETS-1:0] evict_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         evict_q <= '0;
      end else if (touch_en_i) begin
         evict_q[touch_idx_i] <= ~touch_way_i;
      end
   end

   always_comb begin
      if (!way_valid_i[0]) begin
         victim_o = 1'b0;
      end else if (!way_valid_i[1]) begin
         victim_o = 1'b1;
      end else begin
         victim_o = evict_q[rd_idx_i];
      end
   end
endmodule

// File: rtl/sa2c_fill_fsm.sv
// Reads one block from memory, one byte per handshake, in ascending offset order.
module sa2c_fill_fsm
   import sa2c_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int DATA_W = 8,
   parameter int OFF_W  = 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start_i,
   input  logic [ADDR_W-1:0]         addr_i,
   input  logic                      mem_ready_i,
   input  logic [DATA_W-1:0]         mem_data_i,
   output logic                      busy_o,
   output logic                      mem_req_o,
   output logic [ADDR_W-1:0]         mem_addr_o,
   output logic                      done_o,
   output logic [ADDR_W-1:0]         addr_o,
   output logic [(DATA_W<<OFF_W)-1:0] block_o
);
   localparam int BLK    = 1 << OFF_W;
   localparam int LINE_W = ADDR_W - OFF_W;

   fill_state_e               state_q;
   logic [LINE_W-1:0]         line_q;
   logic [OFF_W-1:0]          off_q;
   logic [OFF_W-1:0]          beat_q;
   logic [BLK*DATA_W-1:0]     block_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= FILL_IDLE;
         line_q  <= '0;
         off_q   <= '0;
         beat_q  <= '0;
         block_q <= '0;
      end else begin
         case (state_q)
            FILL_IDLE: begin
               if (start_i) begin
                  line_q  <= addr_i[ADDR_W-1:OFF_W];
                  off_q   <= addr_i[OFF_W-1:0];
                  beat_q  <= '0;
                  state_q <= FILL_BEAT;
               end
            end
            FILL_BEAT: begin
               if (mem_ready_i) begin
                  for (int b = 0; b < BLK; b++) begin
                     if (beat_q == OFF_W'(b)) begin
                        block_q[b*DATA_W +: DATA_W] <= mem_data_i;
                     end
                  end
                  if (beat_q == {OFF_W{1'b1}}) begin
                     state_q <= FILL_DONE;
                  end else begin
                     beat_q <= beat_q + 1'b1;
                  end
               end
            end
            FILL_DONE: state_q <= FILL_IDLE;
            default:   state_q <= FILL_IDLE;
         endcase
      end
   end

   assign busy_o     = (state_q != FILL_IDLE);
   assign mem_req_o  = (state_q == FILL_BEAT);
   assign mem_addr_o = {line_q, beat_q};
   assign done_o     = (state_q == FILL_DONE);
   assign addr_o     = {line_q, off_q};
   assign block_o    = block_q;
endmodule

// File: rtl/sa2c_load_cache.sv
// Two-way set-associative load cache with per-set recency replacement.
module sa2c_load_cache #(
   parameter int ADDR_W = 5,
   parameter int IDX_W  = 1,
   parameter int OFF_W  = 1,
   parameter int DATA_W = 8,
   parameter int WAYS   = 2,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_valid,
   input  logic [ADDR_W-1:0] ld_addr,
   output logic              ld_busy,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic              rsp_hit,
   output logic [CNT_W-1:0]  hit_count,
   output logic [CNT_W-1:0]  miss_count,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ready,
   input  logic [DATA_W-1:0] mem_data
);
   localparam int TAG_W     = ADDR_W - IDX_W - OFF_W;
   localparam int BLK       = 1 << OFF_W;
   localparam int LINE_BITS = BLK * DATA_W;

   if (WAYS != 2) begin : g_bad_ways
      $error("sa2c_load_cache: recency logic supports exactly two ways");
   end
   if (TAG_W < 1) begin : g_bad_split
      $error("sa2c_load_cache: address too narrow for index and offset");
   end

   // lookup address fields
   logic [TAG_W-1:0] lk_tag;
   logic [IDX_W-1:0] lk_idx;
   logic [OFF_W-1:0] lk_off;
   assign lk_tag = ld_addr[ADDR_W-1 -: TAG_W];
   assign lk_idx = ld_addr[OFF_W +: IDX_W];
   assign lk_off = ld_addr[OFF_W-1:0];

   // fill engine
   logic                 fill_busy;
   logic                 fill_done;
   logic [ADDR_W-1:0]    fill_addr;
   logic [LINE_BITS-1:0] fill_block;
   logic                 accept;
   logic                 miss_start;

   assign accept = ld_valid && !fill_busy;

   sa2c_fill_fsm #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .OFF_W  (OFF_W)
   ) u_fill (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (miss_start),
      .addr_i      (ld_addr),
      .mem_ready_i (mem_ready),
      .mem_data_i  (mem_data),
      .busy_o      (fill_busy),
      .mem_req_o   (mem_req),
      .mem_addr_o  (mem_addr),
      .done_o      (fill_done),
      .addr_o      (fill_addr),
      .block_o     (fill_block)
   );

   logic [TAG_W-1:0] fill_tag;
   logic [IDX_W-1:0] fill_idx;
   logic [OFF_W-1:0] fill_off;
   assign fill_tag = fill_addr[ADDR_W-1 -: TAG_W];
   assign fill_idx = fill_addr[OFF_W +: IDX_W];
   assign fill_off = fill_addr[OFF_W-1:0];

   // way storage and tag compare
   logic [WAYS-1:0]      way_valid;
   logic [TAG_W-1:0]     way_tag  [WAYS];
   logic [LINE_BITS-1:0] way_line [WAYS];
   logic [WAYS-1:0]      hit_vec;
   logic                 victim_q;

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic wr_en;
      assign wr_en = fill_done && (victim_q == 1'(w));

      sa2c_way #(
         .TAG_W     (TAG_W),
         .IDX_W     (IDX_W),
         .LINE_BITS (LINE_BITS)
      ) u_way (
         .clk        (clk),
         .rst_n      (rst_n),
         .rd_idx_i   (lk_idx),
         .rd_valid_o (way_valid[w]),
         .rd_tag_o   (way_tag[w]),
         .rd_line_o  (way_line[w]),
         .wr_en_i    (wr_en),
         .wr_idx_i   (fill_idx),
         .wr_tag_i   (fill_tag),
         .wr_line_i  (fill_block)
      );

      assign hit_vec[w] = way_valid[w] && (way_tag[w] == lk_tag);
   end

   logic                 any_hit;
   logic                 hit_way;
   logic [LINE_BITS-1:0] hit_line;
   logic [DATA_W-1:0]    hit_byte;
   logic [DATA_W-1:0]    fill_byte;

   assign any_hit    = |hit_vec;
   assign miss_start = accept && !any_hit;

   always_comb begin
      hit_way  = 1'b0;
      hit_line = way_line[0];
      for (int w = 0; w < WAYS; w++) begin
         if (hit_vec[w]) begin
            hit_way  = 1'(w);
            hit_line = way_line[w];
         end
      end
   end

   always_comb begin
      hit_byte  = '0;
      fill_byte = '0;
      for (int b = 0; b < BLK; b++) begin
         if (lk_off == OFF_W'(b)) begin
            hit_byte = hit_line[b*DATA_W +: DATA_W];
         end
         if (fill_off == OFF_W'(b)) begin
            fill_byte = fill_block[b*DATA_W +: DATA_W];
         end
      end
   end

   // replacement
   logic       victim_now;
   logic       touch_en;
   logic [IDX_W-1:0] touch_idx;
   logic       touch_way;

   assign touch_en  = (accept && any_hit) || fill_done;
   assign touch_idx = fill_done ? fill_idx : lk_idx;
   assign touch_way = fill_done ? victim_q : hit_way;

   sa2c_repl #(
      .IDX_W (IDX_W)
   ) u_repl (
      .clk         (clk),
      .rst_n       (rst_n),
      .rd_idx_i    (lk_idx),
      .way_valid_i (way_valid),
      .victim_o    (victim_now),
      .touch_en_i  (touch_en),
      .touch_idx_i (touch_idx),
      .touch_way_i (touch_way)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         victim_q <= 1'b0;
      end else if (miss_start) begin
         victim_q <= victim_now;
      end
   end

   // response and counters
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_hit    <= 1'b0;
         rsp_data   <= '0;
         hit_count  <= '0;
         miss_count <= '0;
      end else if (accept && any_hit) begin
         rsp_valid <= 1'b1;
         rsp_hit   <= 1'b1;
         rsp_data  <= hit_byte;
         hit_count <= hit_count + 1'b1;
      end else if (fill_done) begin
         rsp_valid  <= 1'b1;
         rsp_hit    <= 1'b0;
         rsp_data   <= fill_byte;
         miss_count <= miss_count + 1'b1;
      end else begin
         rsp_valid <= 1'b0;
      end
   end

   assign ld_busy = fill_busy;
endmodule

// File: rtl/sa2c_load_cache_chk.sv
module sa2c_load_cache_chk #(
   parameter int ADDR_W = 5,
   parameter int OFF_W  = 1,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ld_busy,
   input logic              rsp_valid,
   input logic              rsp_hit,
   input logic [CNT_W-1:0]  hit_count,
   input logic [CNT_W-1:0]  miss_count,
   input logic              mem_req,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_ready
);
   p_req_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ready |=> mem_req && $stable(mem_addr));

   p_req_only_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> ld_busy);

   p_ascending_beats_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_ready && (mem_addr[OFF_W-1:0] != {OFF_W{1'b1}})
      |=> mem_req && (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

   p_hit_counted_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_hit |-> hit_count == CNT_W'($past(hit_count) + 1'b1)
                               && $stable(miss_count));

   p_miss_counted_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_hit |-> miss_count == CNT_W'($past(miss_count) + 1'b1)
                                && $stable(hit_count));

   p_miss_after_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_hit |-> !$past(mem_req));

   p_quiet_counts_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> $stable(hit_count) && $stable(miss_count));

   p_rsp_not_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !ld_busy);
endmodule

bind sa2c_load_cache sa2c_load_cache_chk #(
   .ADDR_W (ADDR_W),
   .OFF_W  (OFF_W),
   .CNT_W  (CNT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ld_busy    (ld_busy),
   .rsp_valid  (rsp_valid),
   .rsp_hit    (rsp_hit),
   .hit_count  (hit_count),
   .miss_count (miss_count),
   .mem_req    (mem_req),
   .mem_addr   (mem_addr),
   .mem_ready  (mem_ready)
);

// File: tb/sa2c_load_cache_tb.sv
`timescale 1ns/1ps
module sa2c_load_cache_tb;
   localparam int LAT  = 2;
   localparam int NVEC = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ld_valid = 1'b0;
   logic [4:0]  ld_addr = '0;
   logic        ld_busy;
   logic        rsp_valid;
   logic [7:0]  rsp_data;
   logic        rsp_hit;
   logic [15:0] hit_count;
   logic [15:0] miss_count;
   logic        mem_req;
   logic [4:0]  mem_addr;
   logic        mem_ready = 1'b0;
   logic [7:0]  mem_data = '0;

   int total = 0;
   int bad = 0;
   int lat_cnt = 0;
   int fetch_n = 0;
   logic [4:0] fetch_log [4];

   always #2 clk = ~clk;

   sa2c_load_cache u_dut (
      .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr),
      .ld_busy(ld_busy), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .rsp_hit(rsp_hit), .hit_count(hit_count), .miss_count(miss_count),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready),
      .mem_data(mem_data)
   );

   function automatic logic [7:0] mem_byte(input logic [4:0] a);
      return 8'(a * 37 + 11);
   endfunction

   // memory model: fixed latency, one ready pulse per byte
   always @(negedge clk) begin
      if (!rst_n || !mem_req) begin
         lat_cnt   = 0;
         mem_ready = 1'b0;
      end else if (mem_ready) begin
         mem_ready = 1'b0;
         lat_cnt   = 0;
      end else if (lat_cnt == LAT) begin
         mem_ready = 1'b1;
         mem_data  = mem_byte(mem_addr);
         if (fetch_n < 4) fetch_log[fetch_n] = mem_addr;
         fetch_n++;
      end else begin
         lat_cnt++;
      end
   end

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   // one load; checks data, hit flag, busy behaviour and memory traffic
   task automatic do_load(input logic [4:0] a, input logic exp_hit);
      logic busy_seen;
      int waited;
      @(negedge clk);
      fetch_n  = 0;
      ld_valid = 1'b1;
      ld_addr  = a;
      @(negedge clk);
      ld_valid  = 1'b0;
      busy_seen = ld_busy;
      waited    = 0;
      while (!rsp_valid && waited < 200) begin
         @(negedge clk);
         waited++;
      end
      chk(rsp_valid, "R3/R5 response arrives", int'(rsp_valid), 1);
      chk(rsp_data == mem_byte(a), "R1 returned byte", rsp_data, mem_byte(a));
      chk(rsp_hit == exp_hit, "R6/R7/R8 hit flag", rsp_hit, exp_hit);
      if (exp_hit) begin
         chk(waited == 0, "R3 hit latency", waited, 0);
         chk(fetch_n == 0, "R3 no memory read on hit", fetch_n, 0);
      end else begin
         chk(busy_seen, "R4 busy during miss", busy_seen, 1);
         chk(fetch_n == 2, "R4 two byte reads", fetch_n, 2);
         chk(fetch_log[0] == {a[4:1], 1'b0}, "R4 first read aligned",
             fetch_log[0], {a[4:1], 1'b0});
         chk(fetch_log[1] == {a[4:1], 1'b1}, "R4 second read ascending",
             fetch_log[1], {a[4:1], 1'b1});
      end
   endtask

   // {address, expected hit}; set = bit 1, tag = bits 4:2
   localparam logic [5:0] VEC [NVEC] = '{
      {5'd1, 1'b0}, {5'd5, 1'b0}, {5'd1, 1'b1}, {5'd4, 1'b1},
      {5'd0, 1'b1}, {5'd12, 1'b0}, {5'd5, 1'b0}, {5'd12, 1'b1},
      {5'd5, 1'b1}, {5'd12, 1'b1}, {5'd5, 1'b1}, {5'd2, 1'b0},
      {5'd3, 1'b1}, {5'd30, 1'b0}, {5'd2, 1'b1}, {5'd14, 1'b0},
      {5'd2, 1'b1}, {5'd31, 1'b0}, {5'd3, 1'b1}, {5'd15, 1'b0}
   };

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
   end

   initial begin
      int hc0;
      int mc0;
      int waited;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R2 reset state
      chk(!ld_busy, "R2 busy low", ld_busy, 0);
      chk(!rsp_valid, "R2 no response", rsp_valid, 0);
      chk(!mem_req, "R2 no memory request", mem_req, 0);
      chk(hit_count == 0, "R2 hit count zero", hit_count, 0);
      chk(miss_count == 0, "R2 miss count zero", miss_count, 0);

      // R6 R7 R8 replacement sequences in both sets
      for (int i = 0; i < NVEC; i++) begin
         do_load(VEC[i][5:1], VEC[i][0]);
      end
      chk(hit_count == 11, "R3 hit total", hit_count, 11);
      chk(miss_count == 9, "R5 miss total", miss_count, 9);

      // R9 strobe while busy is ignored
      hc0 = hit_count;
      mc0 = miss_count;
      @(negedge clk);
      ld_valid = 1'b1;
      ld_addr  = 5'd8;
      @(negedge clk);
      ld_addr = 5'd24;
      waited  = 0;
      while (!rsp_valid && waited < 200) begin
         @(negedge clk);
         waited++;
      end
      ld_valid = 1'b0;
      chk(rsp_data == mem_byte(5'd8), "R9 first load served", rsp_data, mem_byte(5'd8));
      chk(!rsp_hit, "R9 first load missed", rsp_hit, 0);
      chk(miss_count == 16'(mc0 + 1), "R9 one miss counted", miss_count, mc0 + 1);
      chk(hit_count == 16'(hc0), "R9 hits unchanged", hit_count, hc0);
      @(negedge clk);
      chk(!rsp_valid, "R9 no extra response", rsp_valid, 0);
      do_load(5'd24, 1'b0);
      do_load(5'd9, 1'b1);

      // R2 reset clears lines and counters
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(hit_count == 0, "R2 hit count after reset", hit_count, 0);
      chk(miss_count == 0, "R2 miss count after reset", miss_count, 0);
      do_load(5'd9, 1'b0);
      do_load(5'd8, 1'b1);
      chk(miss_count == 1, "R5 miss count after reset", miss_count, 1);
      chk(hit_count == 1, "R3 hit count after reset", hit_count, 1);

      summary();
      $finish;
   end
endmodule